// File: doc/BRIEF.md
# Wrap-Extended Timestamp Counter

This block turns a free-running 16-bit down-counter, which reloads from a programmed period each time it reaches its end, into a 32-bit timestamp that only moves forward. When a read is requested, the counter sample is turned into an up-count by subtracting it from the effective maximum. Each time the counter goes round, the block adds one period to a 32-bit running offset. The result it returns is the up-count plus that offset.

Two sources can notice that the counter has gone round: the read path and the periodic tick handler. A read spots the event in one of two ways. Either the up-count has fallen since the previous read, or the interrupt logic reports a pending tick. When a read advances the offset, it sets a "ticked" flag. When the tick handler later runs and finds that flag set, it clears the flag and does not add the period a second time. A tick and a read that arrive in the same cycle are handled in a fixed order: the tick first, then the read.

Top module: `ts_wrap_counter`

## Requirements
- R1: After reset, rd_valid is low and the offset, the last up-count and the ticked flag are all zero. The first read after reset returns exactly max minus cnt_in.
- R2: The effective maximum is 0xFFFF when period_cfg is 0, which encodes a reload of 65536. For any other value, the maximum equals period_cfg.
- R3: Each cycle with rd_req high produces rd_valid high in the following cycle, with rd_value = up-count + offset (modulo 2^32). rd_valid is low in every cycle that follows one without rd_req.
- R4: The up-count equals the maximum minus cnt_in, modulo 2^16.
- R5: When a read's up-count is below the last up-count, the period is added to the offset before the sum is formed, and the ticked flag is set.
- R6: When a read finds the ticked flag clear and irq_pend high, the offset advances by one period and the flag is set.
- R7: When a read finds the flag clear and raw_pend high, the offset advances and the flag is set if the up-count is below 20, or if irq_masked is high and the up-count is below half the maximum. With raw_pend high and neither condition true, the offset does not change.
- R8: A tick that finds the flag set only clears the flag. A tick that finds it clear adds the period to the offset and zeroes the last up-count.
- R9: When tick and rd_req are both high in one cycle, the tick is applied first and the read sees the resulting offset, last up-count and flag.
- R10: Every read stores its up-count as the last up-count, so the next read compares against it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_cfg | input | 16 | Programmed reload value (0 means 65536) |
| cnt_in | input | 16 | Current down-counter value |
| rd_req | input | 1 | Read request |
| tick | input | 1 | Periodic tick handler runs this cycle |
| irq_pend | input | 1 | Clock interrupt pending (software view) |
| raw_pend | input | 1 | Raw interrupt pending at the controller |
| irq_masked | input | 1 | Interrupts currently masked for the reader |
| rd_valid | output | 1 | Timestamp valid, one cycle after rd_req |
| rd_value | output | 32 | Extended 32-bit timestamp |

## Verification
All of the block's state is observable only through rd_value. A wrong offset shows up on the very next read as a value one period off. A stale ticked flag shows up at the next tick: it either suppresses an advance or adds a duplicate one, and the error is visible on the read that follows that tick. A wrong last up-count is exposed by the first read whose up-count falls between the correct value and the wrong one, because that read takes the wrong wrap decision. The bench therefore interleaves reads directly with ticks, reloads and pending-flag combinations, and compares each result within one cycle.

// File: rtl/ts_wrap_pkg.sv
package ts_wrap_pkg;

  function automatic logic [15:0] f_max_count(input logic [15:0] reload);
    return (reload == 16'd0) ? 16'hFFFF : reload;
  endfunction

  function automatic logic [15:0] f_up_count(input logic [15:0] max_c,
                                             input logic [15:0] down_c);
    return max_c - down_c;
  endfunction

  function automatic logic f_wrap_seen(input logic [15:0] up,
                                       input logic [15:0] last,
                                       input logic        flag,
                                       input logic        ipend,
                                       input logic        rpend,
                                       input logic        masked,
                                       input logic [15:0] max_c,
                                       input logic [15:0] low_thr);
    logic near_start;
    near_start = (up < low_thr) || (masked && (up < (max_c >> 1)));
    return (up < last) || (!flag && (ipend || (rpend && near_start)));
  endfunction

endpackage

// File: rtl/ts_upconv.sv
module ts_upconv #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] down_cnt,
  output logic [CW-1:0] max_cnt,
  output logic [CW-1:0] up_cnt
);
  import ts_wrap_pkg::*;

  always_comb begin
    max_cnt = f_max_count(reload);
    up_cnt  = f_up_count(max_cnt, down_cnt);
  end
endmodule

// File: rtl/ts_wrap_detect.sv
module ts_wrap_detect #(
  parameter int CW        = 16,
  parameter int LOW_THRESH = 20
) (
  input  logic          rd_req,
  input  logic [CW-1:0] up_cnt,
  input  logic [CW-1:0] last_mid,
  input  logic          flag_mid,
  input  logic          irq_pend,
  input  logic          raw_pend,
  input  logic          irq_masked,
  input  logic [CW-1:0] max_cnt,
  output logic          wrap_evt
);
  import ts_wrap_pkg::*;
  localparam logic [CW-1:0] THR = CW'(LOW_THRESH);

  always_comb begin
    wrap_evt = rd_req && f_wrap_seen(up_cnt, last_mid, flag_mid, irq_pend,
                                     raw_pend, irq_masked, max_cnt, THR);
  end
endmodule

// File: rtl/ts_accum.sv
module ts_accum #(
  parameter int CW = 16,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rd_req,
  input  logic          wrap_evt,
  input  logic [CW-1:0] max_cnt,
  input  logic [CW-1:0] up_cnt,
  output logic [CW-1:0] last_mid,
  output logic          flag_mid,
  output logic [OW-1:0] offset_q,
  output logic [CW-1:0] last_q,
  output logic          ticked_q,
  output logic          rd_valid,
  output logic [OW-1:0] rd_value
);
  localparam int PADW = OW - CW;

  logic [OW-1:0] max_ext;
  logic [OW-1:0] off_mid;
  logic [OW-1:0] off_next;
  logic          tick_adds;

  always_comb begin
    max_ext   = {{PADW{1'b0}}, max_cnt};
    tick_adds = tick && !ticked_q;
    off_mid   = tick_adds ? offset_q + max_ext : offset_q;
    last_mid  = tick_adds ? '0 : last_q;
    flag_mid  = tick ? 1'b0 : ticked_q;
    off_next  = wrap_evt ? off_mid + max_ext : off_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q <= '0;
      last_q   <= '0;
      ticked_q <= 1'b0;
      rd_valid <= 1'b0;
      rd_value <= '0;
    end else begin
      offset_q <= off_next;
      ticked_q <= flag_mid | wrap_evt;
      rd_valid <= rd_req;
      if (rd_req) begin
        last_q   <= up_cnt;
        rd_value <= off_next + {{PADW{1'b0}}, up_cnt};
      end else begin
        last_q   <= last_mid;
      end
    end
  end
endmodule

// File: rtl/ts_wrap_counter.sv
module ts_wrap_counter #(
  parameter int CW         = 16,
  parameter int OW         = 32,
  parameter int LOW_THRESH = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_cfg,
  input  logic [CW-1:0] cnt_in,
  input  logic          rd_req,
  input  logic          tick,
  input  logic          irq_pend,
  input  logic          raw_pend,
  input  logic          irq_masked,
  output logic          rd_valid,
  output logic [OW-1:0] rd_value
);
  logic [CW-1:0] max_cnt;
  logic [CW-1:0] up_cnt;
  logic [CW-1:0] last_mid;
  logic          flag_mid;
  logic          wrap_evt;
  logic [OW-1:0] offset_q;
  logic [CW-1:0] last_q;
  logic          ticked_q;

  ts_upconv #(.CW(CW)) u_conv (
    .reload(period_cfg), .down_cnt(cnt_in), .max_cnt(max_cnt), .up_cnt(up_cnt)
  );

  ts_wrap_detect #(.CW(CW), .LOW_THRESH(LOW_THRESH)) u_det (
    .rd_req(rd_req), .up_cnt(up_cnt), .last_mid(last_mid), .flag_mid(flag_mid),
    .irq_pend(irq_pend), .raw_pend(raw_pend), .irq_masked(irq_masked),
    .max_cnt(max_cnt), .wrap_evt(wrap_evt)
  );

  ts_accum #(.CW(CW), .OW(OW)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_req(rd_req), .wrap_evt(wrap_evt),
    .max_cnt(max_cnt), .up_cnt(up_cnt), .last_mid(last_mid), .flag_mid(flag_mid),
    .offset_q(offset_q), .last_q(last_q), .ticked_q(ticked_q),
    .rd_valid(rd_valid), .rd_value(rd_value)
  );
endmodule

// File: rtl/ts_wrap_counter_chk.sv
module ts_wrap_counter_chk #(
  parameter int CW = 16,
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          tick,
  input logic          rd_valid,
  input logic          wrap_evt,
  input logic [CW-1:0] up_cnt,
  input logic [CW-1:0] max_cnt,
  input logic [OW-1:0] offset_q,
  input logic [CW-1:0] last_q,
  input logic          ticked_q
);
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r3_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  a_r5_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ticked_q);
  a_r8_tick_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ticked_q && !rd_req) |=> (!ticked_q && $stable(offset_q)));
  a_r8_tick_adds_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ticked_q && !rd_req) |=>
      (offset_q == $past(offset_q) + OW'($past(max_cnt)) && last_q == '0));
  a_r10_last_tracks_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (last_q == $past(up_cnt)));
endmodule

bind ts_wrap_counter ts_wrap_counter_chk #(.CW(CW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .tick(tick), .rd_valid(rd_valid),
  .wrap_evt(wrap_evt), .up_cnt(up_cnt), .max_cnt(max_cnt), .offset_q(offset_q),
  .last_q(last_q), .ticked_q(ticked_q)
);

// File: tb/ts_wrap_counter_tb.sv
module ts_wrap_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period_cfg = 16'd1000;
  logic [15:0] cnt_in = '0;
  logic        rd_req = 1'b0, tick = 1'b0, irq_pend = 1'b0;
  logic        raw_pend = 1'b0, irq_masked = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_value;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference state
  longint m_off = 0;
  longint m_last = 0;
  bit     m_flag = 1'b0;

  always #2 clk = ~clk;

  ts_wrap_counter dut_i (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .cnt_in(cnt_in),
    .rd_req(rd_req), .tick(tick), .irq_pend(irq_pend), .raw_pend(raw_pend),
    .irq_masked(irq_masked), .rd_valid(rd_valid), .rd_value(rd_value)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit rd, input bit tk, input bit ip,
                      input bit rp, input bit mk, input int c);
    longint mx, up;
    bit ev;
    rd_req = rd; tick = tk; irq_pend = ip; raw_pend = rp; irq_masked = mk;
    cnt_in = 16'(c);
    mx = (period_cfg == 0) ? 65535 : longint'(period_cfg);
    if (tk) begin
      if (m_flag) m_flag = 1'b0;
      else begin m_off += mx; m_last = 0; end
    end
    up = (mx - c) & 64'hFFFF;
    if (rd) begin
      ev = (up < m_last) ||
           (!m_flag && (ip || (rp && (up < 20 || (mk && up < mx / 2)))));
      if (ev) begin m_off += mx; m_flag = 1'b1; end
      m_last = up;
    end
    @(posedge clk); #1;
    check({tag, " valid"}, longint'(rd_valid), longint'(rd));
    if (rd) check({tag, " value"}, longint'(rd_value), (m_off + up) & 64'hFFFFFFFF);
    rd_req = 1'b0; tick = 1'b0; irq_pend = 1'b0; raw_pend = 1'b0; irq_masked = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rd_valid", longint'(rd_valid), 0);
    rst_n = 1'b1;
    // R1/R4: first read after reset, zero offset
    step("R1", 1, 0, 0, 0, 0, 900);
    step("R4", 1, 0, 0, 0, 0, 500);
    step("R3 idle", 0, 0, 0, 0, 0, 400);
    // R10/R5: counter reloaded -> up-count drops
    step("R10", 1, 0, 0, 0, 0, 300);
    step("R5", 1, 0, 0, 0, 0, 950);
    // R8: tick with flag set only clears it
    step("R8 flag", 0, 1, 0, 0, 0, 900);
    step("R8 after", 1, 0, 0, 0, 0, 800);
    // R8: tick with flag clear adds period, last zeroed
    step("R8 add", 0, 1, 0, 0, 0, 700);
    step("R8 read", 1, 0, 0, 0, 0, 900);
    // R6: irq pending with flag clear
    step("R6", 1, 0, 1, 0, 0, 850);
    step("R6 tick", 0, 1, 0, 0, 0, 850);
    // R7: raw pending, up below threshold
    step("R7 pre", 0, 1, 0, 0, 0, 995);
    step("R7 low", 1, 0, 0, 1, 0, 995);
    step("R7 tick", 0, 1, 0, 0, 0, 900);
    // R7: raw pending, masked, below half
    step("R7 mask", 1, 0, 0, 1, 1, 700);
    step("R7 tick2", 0, 1, 0, 0, 0, 600);
    step("R7 tick3", 0, 1, 0, 0, 0, 650);
    // R7: raw pending but neither condition -> no effect
    step("R7 none", 1, 0, 0, 1, 0, 600);
    step("R7 none2", 1, 0, 0, 1, 1, 300);
    // R9: tick and read together, tick first
    step("R9 both", 1, 1, 0, 0, 0, 200);
    step("R9 again", 1, 1, 0, 0, 0, 900);
    step("R9 next", 1, 0, 0, 0, 0, 850);
    // R2: period 0 means maximum 0xFFFF
    period_cfg = 16'd0;
    step("R2 a", 1, 1, 0, 0, 0, 65000);
    step("R2 b", 1, 0, 0, 0, 0, 100);
    step("R2 c", 1, 0, 0, 0, 0, 65530);
    step("R2 tick", 0, 1, 0, 0, 0, 60000);
    step("R2 d", 1, 0, 0, 0, 0, 50000);
    // mixed sweep
    period_cfg = 16'd300;
    for (int i = 0; i < 60; i++)
      step("R3 sweep", (i % 3) != 1, (i % 7) == 0, (i % 11) == 5, (i % 5) == 2,
           (i % 4) == 0, 299 - ((i * 37) % 300));
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule